// File: doc/BRIEF.md
# Interrupt Arbitration and Vectoring Unit

This unit gathers every interrupt request that a small processor core can receive and turns the winner into a branch vector and a one-cycle acknowledge strobe. The sources are a reset request, a software trap that carries its own vector number, a nonmaskable request (an active-low pin or a software command), and a set of maskable pins. Each maskable pin has its own enable bit. A global disable bit gates all maskable sources.

Requests are latched into pending state on the clock edge after they appear. In the following cycle the unit presents `ack` together with the vector address of the highest-priority pending request. At the end of that cycle the unit clears the winner's pending state and forces the global disable bit to 1. The core treats `ack` as its take strobe and branches to `vecOut`. The core can clear pending flags by writing 1s to them, and it can write the global disable bit directly.

Top module: `irqArbiter`

## Requirements
- R1: After the asynchronous reset `rstN`, `ack` is 0, `flagsOut` is all zeros and `modeOut` (the global disable bit) is 1.
- R2: A pin request on `irqPins[i]` while `maskBits[i]` is 0 does not set `flagsOut[i]` and causes no acknowledge.
- R3: A pin request on `irqPins[i]` while `maskBits[i]` is 1 sets `flagsOut[i]`, which is visible one cycle later.
- R4: A `resetReq` pulse wins over every other source. It produces an acknowledge with vector 16'h0000, and at the end of that cycle it clears all pending flags, the pending trap and the pending nonmaskable request, and sets `modeOut` to 1.
- R5: A falling edge on `nmiPinN` produces exactly one acknowledge with vector 16'h0024, whatever the value of `modeOut`. A pin that stays low or stays high produces no further acknowledges.
- R6: A `nmiCmd` pulse produces exactly one acknowledge with vector 16'h0024, whatever the value of `modeOut`.
- R7: A `trapReq` pulse with operand `trapNum` = K produces an acknowledge with vector 2·K (K from 0 to 31), and this happens even while `modeOut` is 1.
- R8: When several requests are pending, they are served in a fixed order: reset, then trap, then nonmaskable, then maskable flags with the lowest index first.
- R9: A pending maskable flag i is acknowledged only while `modeOut` is 0. Its vector is 2·(i+1), and the flag is cleared at the end of the acknowledge cycle.
- R10: Every acknowledge sets `modeOut` to 1 on the next cycle. This holds even when the core writes 0 to the bit in the same cycle.
- R11: With `flagClrWe` high, a 1 in `flagClrData[i]` clears `flagsOut[i]`. A new unmasked request on the same source in the same cycle wins, and the flag stays set. A new request that arrives during the flag's own acknowledge cycle also keeps the flag set.
- R12: A write through `modeWe`/`modeWData` changes `modeOut` on the next cycle, not in the cycle of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset of all state |
| resetReq | input | 1 | Reset interrupt request pulse |
| irqPins | input | NUM_SRC | Maskable request pins, one per source |
| maskBits | input | NUM_SRC | Per-source enable; 1 lets the pin set its flag |
| nmiPinN | input | 1 | Active-low nonmaskable pin, falling-edge sensitive |
| nmiCmd | input | 1 | Software nonmaskable request pulse |
| trapReq | input | 1 | Software trap request pulse |
| trapNum | input | TRAP_W | Trap operand K; vector is 2·K |
| flagClrWe | input | 1 | Write strobe for clearing flags |
| flagClrData | input | NUM_SRC | Write-1-to-clear data for the flags |
| modeWe | input | 1 | Write strobe for the global disable bit |
| modeWData | input | 1 | Value written to the global disable bit |
| ack | output | 1 | Take strobe: a request is being taken this cycle |
| vecOut | output | 16 | Vector address of the request being taken |
| flagsOut | output | NUM_SRC | Pending maskable flags |
| modeOut | output | 1 | Global disable bit; 1 blocks maskable sources |

## Verification
The collisions of interest are a take of a request and a core write that lands in the same cycle. One case is the core writing 0 to the global disable bit while an acknowledge is active. The other is a write-1-to-clear, or a fresh request on the same pin, arriving during that flag's acknowledge cycle or in the same cycle as a new request. The bench drives the core write, or the repeated pin request, on the exact cycle in which `ack` is high. On the next cycle it judges the outcome at the ports: `modeOut` must read 1, and `flagsOut` must keep the freshly requested bit. A scoreboard queue of expected vectors catches any acknowledge that appears out of order or that should not appear at all.

// File: rtl/irqArbPkg.sv
package irqArbPkg;
  // Widest index supported for maskable sources
  localparam int unsigned IDX_W   = 4;
  localparam int unsigned MAX_SRC = 1 << IDX_W;
  localparam int unsigned VEC_W   = 16;

  localparam logic [VEC_W-1:0] RST_VEC = 16'h0000;
  localparam logic [VEC_W-1:0] NMI_VEC = 16'h0024;

  // Strobes from arbitration control to the datapath
  typedef struct packed {
    logic             takeRst;
    logic             takeTrap;
    logic             takeNmi;
    logic             takeIrq;
    logic [IDX_W-1:0] irqIdx;
  } takeStrb_t;
endpackage

// File: rtl/irqArbNmiEdge.sv
module irqArbNmiEdge (
  input  logic clk,
  input  logic rstN,
  input  logic pinN,
  output logic fall
);
  logic prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b1;
    else       prevQ <= pinN;
  end

  assign fall = prevQ & ~pinN;
endmodule

// File: rtl/irqArbControl.sv
module irqArbControl
  import irqArbPkg::*;
#(
  parameter int unsigned NUM_SRC = 6
) (
  input  logic               rstPend,
  input  logic               trapPend,
  input  logic               nmiPend,
  input  logic [NUM_SRC-1:0] flags,
  input  logic               modeBit,
  output takeStrb_t          strb
);
  logic             anyIrq;
  logic [IDX_W-1:0] lowIdx;

  // Lowest pending index wins among maskable sources
  always_comb begin
    lowIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (flags[i]) lowIdx = IDX_W'(i);
    end
  end

  assign anyIrq = |flags;

  always_comb begin
    strb          = '0;
    strb.irqIdx   = lowIdx;
    if (rstPend)                  strb.takeRst  = 1'b1;
    else if (trapPend)            strb.takeTrap = 1'b1;
    else if (nmiPend)             strb.takeNmi  = 1'b1;
    else if (anyIrq && !modeBit)  strb.takeIrq  = 1'b1;
  end
endmodule

// File: rtl/irqArbDatapath.sv
module irqArbDatapath
  import irqArbPkg::*;
#(
  parameter int unsigned NUM_SRC = 6,
  parameter int unsigned TRAP_W  = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               resetReq,
  input  logic [NUM_SRC-1:0] irqPins,
  input  logic [NUM_SRC-1:0] maskBits,
  input  logic               nmiFall,
  input  logic               nmiCmd,
  input  logic               trapReq,
  input  logic [TRAP_W-1:0]  trapNum,
  input  logic               flagClrWe,
  input  logic [NUM_SRC-1:0] flagClrData,
  input  logic               modeWe,
  input  logic               modeWData,
  input  takeStrb_t          strb,
  output logic               rstPendQ,
  output logic               trapPendQ,
  output logic               nmiPendQ,
  output logic [NUM_SRC-1:0] flagsQ,
  output logic               modeQ,
  output logic               ackOut,
  output logic [VEC_W-1:0]   vecOut
);
  logic [TRAP_W-1:0]  trapNumQ;
  logic [NUM_SRC-1:0] setMask;
  logic [NUM_SRC-1:0] clrMask;
  logic [NUM_SRC-1:0] takeMask;

  assign ackOut   = strb.takeRst | strb.takeTrap | strb.takeNmi | strb.takeIrq;
  assign setMask  = irqPins & maskBits;
  assign takeMask = strb.takeIrq ? (NUM_SRC'(1) << strb.irqIdx) : '0;
  assign clrMask  = (flagClrWe ? flagClrData : '0) | takeMask;

  // Pending flags: a new request wins over any clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             flagsQ <= '0;
    else if (strb.takeRst) flagsQ <= '0;
    else                   flagsQ <= (flagsQ & ~clrMask) | setMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstPendQ  <= 1'b0;
      nmiPendQ  <= 1'b0;
      trapPendQ <= 1'b0;
      trapNumQ  <= '0;
    end else begin
      rstPendQ <= resetReq | (rstPendQ & ~strb.takeRst);
      if (strb.takeRst) begin
        nmiPendQ  <= 1'b0;
        trapPendQ <= 1'b0;
      end else begin
        nmiPendQ <= (nmiPendQ & ~strb.takeNmi) | nmiFall | nmiCmd;
        if (trapReq) begin
          trapPendQ <= 1'b1;
          trapNumQ  <= trapNum;
        end else if (strb.takeTrap) begin
          trapPendQ <= 1'b0;
        end
      end
    end
  end

  // Global disable bit: any take forces it high, over a core write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       modeQ <= 1'b1;
    else if (ackOut) modeQ <= 1'b1;
    else if (modeWe) modeQ <= modeWData;
  end

  always_comb begin
    vecOut = '0;
    if (strb.takeRst)       vecOut = RST_VEC;
    else if (strb.takeTrap) vecOut = VEC_W'({trapNumQ, 1'b0});
    else if (strb.takeNmi)  vecOut = NMI_VEC;
    else if (strb.takeIrq)  vecOut = VEC_W'((32'(strb.irqIdx) + 32'd1) << 1);
  end

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_flagChk
      // R2
      masked_no_set_chk: assert property (@(posedge clk) disable iff (!rstN)
        (irqPins[i] && !maskBits[i] && !flagsQ[i]) |=> !flagsQ[i]);
      // R3
      unmasked_set_chk: assert property (@(posedge clk) disable iff (!rstN)
        (irqPins[i] && maskBits[i] && !strb.takeRst) |=> flagsQ[i]);
    end
  endgenerate

  // R10
  take_sets_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackOut |=> modeQ);

  // R9
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.takeIrq |-> !modeQ);

  // R4
  rst_clears_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.takeRst |=> (flagsQ == '0 && !nmiPendQ && !trapPendQ && modeQ));

  // R12
  mode_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeWe && !ackOut) |=> (modeQ == $past(modeWData)));

  // R8
  trap_beats_nmi_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trapPendQ && !rstPendQ) |-> (strb.takeTrap && !strb.takeNmi));
endmodule

// File: rtl/irqArbiter.sv
module irqArbiter
  import irqArbPkg::*;
#(
  parameter int unsigned NUM_SRC = 6,
  parameter int unsigned TRAP_W  = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               resetReq,
  input  logic [NUM_SRC-1:0] irqPins,
  input  logic [NUM_SRC-1:0] maskBits,
  input  logic               nmiPinN,
  input  logic               nmiCmd,
  input  logic               trapReq,
  input  logic [TRAP_W-1:0]  trapNum,
  input  logic               flagClrWe,
  input  logic [NUM_SRC-1:0] flagClrData,
  input  logic               modeWe,
  input  logic               modeWData,
  output logic               ack,
  output logic [15:0]        vecOut,
  output logic [NUM_SRC-1:0] flagsOut,
  output logic               modeOut
);
  takeStrb_t          strb;
  logic               nmiFall;
  logic               rstPend;
  logic               trapPend;
  logic               nmiPend;
  logic [NUM_SRC-1:0] flags;
  logic               modeBit;
  logic [VEC_W-1:0]   vec;

  irqArbNmiEdge u_nmiEdge (
    .clk  (clk),
    .rstN (rstN),
    .pinN (nmiPinN),
    .fall (nmiFall)
  );

  irqArbControl #(.NUM_SRC(NUM_SRC)) u_ctrl (
    .rstPend  (rstPend),
    .trapPend (trapPend),
    .nmiPend  (nmiPend),
    .flags    (flags),
    .modeBit  (modeBit),
    .strb     (strb)
  );

  irqArbDatapath #(.NUM_SRC(NUM_SRC), .TRAP_W(TRAP_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .resetReq    (resetReq),
    .irqPins     (irqPins),
    .maskBits    (maskBits),
    .nmiFall     (nmiFall),
    .nmiCmd      (nmiCmd),
    .trapReq     (trapReq),
    .trapNum     (trapNum),
    .flagClrWe   (flagClrWe),
    .flagClrData (flagClrData),
    .modeWe      (modeWe),
    .modeWData   (modeWData),
    .strb        (strb),
    .rstPendQ    (rstPend),
    .trapPendQ   (trapPend),
    .nmiPendQ    (nmiPend),
    .flagsQ      (flags),
    .modeQ       (modeBit),
    .ackOut      (ack),
    .vecOut      (vec)
  );

  assign vecOut   = vec;
  assign flagsOut = flags;
  assign modeOut  = modeBit;
endmodule

// File: tb/irqArbiter_tb.sv
module irqArbiter_tb;
  localparam int unsigned NS = 6;
  localparam int unsigned TW = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          resetReq = 1'b0;
  logic [NS-1:0] irqPins = '0;
  logic [NS-1:0] maskBits = '0;
  logic          nmiPinN = 1'b1;
  logic          nmiCmd = 1'b0;
  logic          trapReq = 1'b0;
  logic [TW-1:0] trapNum = '0;
  logic          flagClrWe = 1'b0;
  logic [NS-1:0] flagClrData = '0;
  logic          modeWe = 1'b0;
  logic          modeWData = 1'b0;
  logic          ack;
  logic [15:0]   vecOut;
  logic [NS-1:0] flagsOut;
  logic          modeOut;

  typedef struct {
    logic [15:0] vec;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  int total = 0;
  int bad = 0;
  int ackSeen = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  irqArbiter #(.NUM_SRC(NS), .TRAP_W(TW)) u_dut (
    .clk(clk), .rstN(rstN), .resetReq(resetReq), .irqPins(irqPins),
    .maskBits(maskBits), .nmiPinN(nmiPinN), .nmiCmd(nmiCmd),
    .trapReq(trapReq), .trapNum(trapNum), .flagClrWe(flagClrWe),
    .flagClrData(flagClrData), .modeWe(modeWe), .modeWData(modeWData),
    .ack(ack), .vecOut(vecOut), .flagsOut(flagsOut), .modeOut(modeOut)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expectVec(logic [15:0] v, string tag);
    expItem_t it;
    it.vec = v;
    it.tag = tag;
    expQ.push_back(it);
  endtask

  // Advance to the next falling edge and drop all one-cycle pulses
  task automatic idle();
    @(negedge clk);
    resetReq = 1'b0; irqPins = '0; nmiCmd = 1'b0; trapReq = 1'b0;
    flagClrWe = 1'b0; flagClrData = '0; modeWe = 1'b0;
  endtask

  task automatic writeMode(logic v);
    modeWe = 1'b1; modeWData = v;
    idle();
  endtask

  // Monitor: pop and compare every acknowledge
  always @(negedge clk) begin
    if (rstN && ack) begin
      ackSeen++;
      total++;
      if (expQ.size() == 0) begin
        bad++;
        $display("FAIL unexpected ack actual=%0h expected=none", vecOut);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        if (vecOut !== it.vec) begin
          bad++;
          $display("FAIL %s vector actual=%0h expected=%0h", it.tag, vecOut, it.vec);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle();
    // R1 reset state
    check("R1 ack", ack, 0);
    check("R1 flags", flagsOut, 0);
    check("R1 mode", modeOut, 1);

    // R12 mode write seen only after the edge
    modeWe = 1'b1; modeWData = 1'b0;
    check("R12 same cycle", modeOut, 1);
    idle();
    check("R12 next cycle", modeOut, 0);

    // R2 masked pin
    maskBits = '0; irqPins = 6'b000100;
    idle();
    check("R2 flags", flagsOut, 0);
    check("R2 mode untouched", modeOut, 0);

    // R3 / R9 unmasked pin taken
    maskBits = '1; irqPins = 6'b001000;
    expectVec(16'd8, "R9 idx3");
    idle();
    check("R3 flag set", flagsOut, 6'b001000);
    idle();
    check("R9 flag cleared", flagsOut, 0);
    check("R10 mode after take", modeOut, 1);

    // R9 blocked while mode is 1
    irqPins = 6'b000010;
    idle();
    check("R9 held pending", flagsOut, 6'b000010);
    check("R9 no ack", ack, 0);
    expectVec(16'd4, "R9 idx1");
    writeMode(1'b0);
    idle();
    check("R9 cleared after take", flagsOut, 0);

    // R8 lowest index first
    writeMode(1'b0);
    irqPins = 6'b101000;
    expectVec(16'd8, "R8 idx3 first");
    idle();
    idle();
    check("R8 idx5 waits", flagsOut, 6'b100000);
    expectVec(16'd12, "R8 idx5 second");
    writeMode(1'b0);
    idle();
    check("R8 all served", flagsOut, 0);

    // R5 nmi pin edge, mode is 1
    base = ackSeen;
    nmiPinN = 1'b0;
    expectVec(16'h0024, "R5 nmi pin");
    repeat (4) idle();
    nmiPinN = 1'b1;
    repeat (3) idle();
    check("R5 one ack only", ackSeen - base, 1);

    // R6 nmi command
    base = ackSeen;
    nmiCmd = 1'b1;
    expectVec(16'h0024, "R6 nmi cmd");
    repeat (3) idle();
    check("R6 one ack", ackSeen - base, 1);

    // R7 traps while mode is 1
    trapReq = 1'b1; trapNum = 5'd9;
    expectVec(16'd18, "R7 K9");
    idle();
    trapReq = 1'b1; trapNum = 5'd31;
    expectVec(16'd62, "R7 K31");
    idle();
    trapReq = 1'b1; trapNum = 5'd18;
    expectVec(16'h0024, "R7 K18");
    repeat (2) idle();
    check("R7 mode", modeOut, 1);

    // R8 trap > nmi > maskable in one cycle
    writeMode(1'b0);
    trapReq = 1'b1; trapNum = 5'd20; nmiCmd = 1'b1; irqPins = 6'b000001;
    expectVec(16'd40, "R8 trap first");
    expectVec(16'h0024, "R8 nmi second");
    repeat (3) idle();
    check("R8 maskable blocked", flagsOut, 6'b000001);

    // R11 write-1-to-clear
    flagClrWe = 1'b1; flagClrData = 6'b000001;
    idle();
    check("R11 cleared", flagsOut, 0);

    // R11 set wins over clear
    irqPins = 6'b000100; flagClrWe = 1'b1; flagClrData = 6'b000100;
    idle();
    check("R11 set wins", flagsOut, 6'b000100);
    flagClrWe = 1'b1; flagClrData = '1;
    idle();
    check("R11 clear all", flagsOut, 0);

    // R10 take collides with core write of 0 and a repeat request
    writeMode(1'b0);
    irqPins = 6'b010000;
    expectVec(16'd10, "R10 idx4");
    idle();
    check("R10 ack cycle", ack, 1);
    modeWe = 1'b1; modeWData = 1'b0; irqPins = 6'b010000;
    idle();
    check("R10 take wins mode", modeOut, 1);
    check("R11 re-request kept", flagsOut, 6'b010000);

    // R4 reset request beats everything and clears all
    resetReq = 1'b1; nmiCmd = 1'b1; trapReq = 1'b1; trapNum = 5'd3;
    irqPins = 6'b000110;
    expectVec(16'h0000, "R4 reset");
    idle();
    check("R4 ack", ack, 1);
    idle();
    check("R4 flags cleared", flagsOut, 0);
    check("R4 mode", modeOut, 1);
    repeat (3) idle();
    check("R4 nothing left", expQ.size(), 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule